// File: doc/BRIEF.md
# SD Command Issue and Response Capture Engine

This block runs the command half of an SD/MMC host controller. Software places a 32-bit argument in an argument register. It then writes a command word, and that write starts a transaction. The engine builds a 48-bit command frame with its CRC7 and shifts it out on the CMD line, one bit per SD clock enable strobe. It then listens for the card's answer. The length of the answer comes from the response-type field of the command word.

A short answer yields a 32-bit card status. A long answer yields 120 payload bits. These are spread across four 32-bit response registers with the CRC byte dropped, so software must shift the words left by 8 to rebuild the register image. A response-done flag and a set of error flags report the outcome. The flags stay set until software writes zero over them. The SD clock itself, the data lines and card detect are handled elsewhere. The engine only sees `sd_tick`, a one-cycle strobe that marks each SD clock period.

Top module: `sd_cmd_engine`

## Requirements
- R1: After reset, every readable register is 0. `cmd_out` is 1, `cmd_oe` is 0, and the busy flag (bit 14 of the error/busy status register at 0x03c) is 0.
- R2: A command frame is 48 bits sent MSB first, one bit per `sd_tick`, with `cmd_oe` high for exactly those 48 ticks. The fields are, in order: 0, 1, the 6-bit index, the 32-bit argument, CRC7 over the first 40 bits (polynomial x^7+x^3+1), and a closing 1. Between strobes the line holds its bit.
- R3: The command word is decoded as follows. Bits 5:0 are the index and bits 10:8 are the response type: 3 means no response, 6 means a 136-bit response, and any other value means a 48-bit response. Bits 6, 11, 12, 13 and 14 are stored and read back at 0x000, but they do not change the frame.
- R4: The busy flag is 1 from the accepted command write until the transaction ends. A write to the command register while busy is ignored: the stored word and the frame on the line are unchanged, and no second frame is sent.
- R5: For a 48-bit response, response bits 39:8 (the card status) appear at 0x018. Bit 0 of the done status register at 0x038 becomes 1.
- R6: For a 136-bit response, response bits 127:104 appear in bits 23:0 of 0x030, with bits 31:24 read as 0. Bits 103:72 appear at 0x028, bits 71:40 at 0x020, and bits 39:8 at 0x018.
- R7: The engine samples the line on 64 consecutive strobes after the end bit. If all 64 samples are 1, it sets bit 6 of 0x03c and clears busy. In that case the done flag stays 0 and the response registers are unchanged. A start bit on the 64th sample is still accepted.
- R8: For a 48-bit response other than type 7, bit 1 of 0x03c is set if the received CRC7 does not match the one computed over response bits 47:8. Types 6 and 7 are never flagged.
- R9: Bit 2 of 0x03c is set when the last response bit is 0.
- R10: Bit 0 of 0x03c is set when response bits 45:40 differ from the command index. Types 6 and 7 skip this check.
- R11: With response type 3, the done flag is set as soon as the end bit has been sent and busy clears. Later activity on `cmd_in` changes no register.
- R12: Writing to 0x038 or 0x03c clears every flag whose written bit is 0 and keeps every flag whose written bit is 1. The busy flag is not affected by such writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_tick | input | 1 | One-cycle strobe marking one SD clock period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | AW | Register read byte offset |
| rd_data | output | 32 | Register read data, combinational |
| cmd_in | input | 1 | Sampled CMD line from the card |
| cmd_out | output | 1 | CMD line value driven by the host |
| cmd_oe | output | 1 | High while the host drives the CMD line |

## Verification
Frames are generated with distinct indices and arguments, and the monitor compares every bit. A wrong CRC7 shift or a misplaced field would therefore show up as a different frame. The card model sends the following responses:
- a clean R1, which separates short-response capture from the error paths;
- a R2 and a R3 carrying bad CRC bytes and a foreign index, which show that those checks are skipped only for those types;
- R1 responses with a single corrupted CRC, end bit or index, each of which must raise exactly one distinct flag.

Idle gaps of 63 and 64 strobes mark the edge of the response timeout. A command written while busy, together with a no-response command followed by line activity, confirms that ignored stimulus leaves the registers and the line untouched.

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine #(
  parameter int AW        = 10,
  parameter int TMO_TICKS = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sd_tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  input  logic          cmd_in,
  output logic          cmd_out,
  output logic          cmd_oe
);

  localparam int TW = $clog2(TMO_TICKS + 1);
  localparam logic [AW-1:0] A_CMD = 'h000;
  localparam logic [AW-1:0] A_ARG = 'h008;
  localparam logic [AW-1:0] A_R10 = 'h018;
  localparam logic [AW-1:0] A_R32 = 'h020;
  localparam logic [AW-1:0] A_R54 = 'h028;
  localparam logic [AW-1:0] A_R76 = 'h030;
  localparam logic [AW-1:0] A_ST1 = 'h038;
  localparam logic [AW-1:0] A_ST2 = 'h03c;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_RECV} state_t;

  state_t        st;
  logic [14:0]   cmd_q;
  logic [31:0]   arg_q;
  logic [47:0]   tx_sr;
  logic [126:0]  rx_sr;
  logic [7:0]    cnt;
  logic [TW-1:0] wcnt;
  logic [31:0]   rsp10, rsp32, rsp54;
  logic [23:0]   rsp76;
  logic          done, e_rto, e_end, e_crc, e_idx;

  function automatic logic [6:0] crc7(input logic [39:0] d);
    logic [6:0] c;
    logic       fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  wire [2:0]   rtype    = cmd_q[10:8];
  wire         long_rsp = (rtype == 3'd6);
  wire         no_rsp   = (rtype == 3'd3);
  wire         skip_chk = long_rsp || (rtype == 3'd7);
  wire [7:0]   last_bit = long_rsp ? 8'd135 : 8'd47;
  wire [127:0] rx_next  = {rx_sr, cmd_in};
  wire         busy     = (st != S_IDLE);
  wire         cmd_wr   = wr_en && (wr_addr == A_CMD) && !busy;

  assign cmd_oe  = (st == S_SEND);
  assign cmd_out = cmd_oe ? tx_sr[47] : 1'b1;

  always_comb begin
    case (rd_addr)
      A_CMD:   rd_data = {17'b0, cmd_q};
      A_ARG:   rd_data = arg_q;
      A_R10:   rd_data = rsp10;
      A_R32:   rd_data = rsp32;
      A_R54:   rd_data = rsp54;
      A_R76:   rd_data = {8'b0, rsp76};
      A_ST1:   rd_data = {31'b0, done};
      A_ST2:   rd_data = {17'b0, busy, 7'b0, e_rto, 3'b0, e_end, e_crc, e_idx};
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cmd_q <= '0;
      arg_q <= '0;
      tx_sr <= '0;
      rx_sr <= '0;
      cnt   <= '0;
      wcnt  <= '0;
      rsp10 <= '0;
      rsp32 <= '0;
      rsp54 <= '0;
      rsp76 <= '0;
      done  <= 1'b0;
      e_rto <= 1'b0;
      e_end <= 1'b0;
      e_crc <= 1'b0;
      e_idx <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_ARG) arg_q <= wr_data;
      if (wr_en && wr_addr == A_ST1) done <= done & wr_data[0];
      if (wr_en && wr_addr == A_ST2) begin
        e_rto <= e_rto & wr_data[6];
        e_end <= e_end & wr_data[2];
        e_crc <= e_crc & wr_data[1];
        e_idx <= e_idx & wr_data[0];
      end
      case (st)
        S_IDLE: if (cmd_wr) begin
          cmd_q <= wr_data[14:0];
          tx_sr <= {2'b01, wr_data[5:0], arg_q, crc7({2'b01, wr_data[5:0], arg_q}), 1'b1};
          cnt   <= '0;
          st    <= S_SEND;
        end
        S_SEND: if (sd_tick) begin
          tx_sr <= {tx_sr[46:0], 1'b1};
          cnt   <= cnt + 8'd1;
          if (cnt == 8'd47) begin
            cnt  <= '0;
            wcnt <= '0;
            if (no_rsp) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              st <= S_WAIT;
            end
          end
        end
        S_WAIT: if (sd_tick) begin
          if (!cmd_in) begin
            rx_sr <= rx_next[126:0];
            cnt   <= 8'd1;
            st    <= S_RECV;
          end else if (wcnt == TW'(TMO_TICKS - 1)) begin
            e_rto <= 1'b1;
            st    <= S_IDLE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        S_RECV: if (sd_tick) begin
          rx_sr <= rx_next[126:0];
          cnt   <= cnt + 8'd1;
          if (cnt == last_bit) begin
            st    <= S_IDLE;
            done  <= 1'b1;
            rsp10 <= rx_next[39:8];
            if (long_rsp) begin
              rsp32 <= rx_next[71:40];
              rsp54 <= rx_next[103:72];
              rsp76 <= rx_next[127:104];
            end
            if (!rx_next[0]) e_end <= 1'b1;
            if (!skip_chk && rx_next[7:1] != crc7(rx_next[47:8])) e_crc <= 1'b1;
            if (!skip_chk && rx_next[45:40] != cmd_q[5:0]) e_idx <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_frame_starts_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |-> !cmd_out);

  assert_line_holds_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_oe && !sd_tick) |=> (cmd_oe && $stable(cmd_out)));

  assert_busy_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CMD && busy) |=> $stable(cmd_q));

  assert_done_ends_transaction_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) && !busy));

  assert_timeout_from_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(e_rto) |-> ($past(st == S_WAIT) && !done));

  assert_rsp_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |=> ($stable(rsp10) && $stable(rsp76)));

endmodule

// File: tb/sim_sd_cmd_engine.sv
module sim_sd_cmd_engine;
  logic        clk = 1'b0, rst_n = 1'b0, sd_tick = 1'b0, wr_en = 1'b0, cmd_in = 1'b1;
  logic [9:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        cmd_out, cmd_oe;

  sd_cmd_engine #(.AW(10), .TMO_TICKS(64)) u0 (
    .clk(clk), .rst_n(rst_n), .sd_tick(sd_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cmd_in(cmd_in),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe));

  always #4 clk = ~clk;

  int          n_chk = 0, n_bad = 0, tdiv = 0, mon_n = 0;
  logic [47:0] exp_q[$];
  logic [47:0] mon_sr = '0, mon_exp;
  logic [31:0] v, last_r10;
  bit          finished = 0;

  function automatic logic [6:0] bcrc(input logic [39:0] d);
    logic [6:0] r = 7'h00;
    for (int i = 39; i >= 0; i--) begin
      logic b;
      b = d[i] ^ r[6];
      r = {r[5:3], r[2] ^ b, r[1:0], b};
    end
    return r;
  endfunction

  function automatic logic [135:0] mk_short(input logic [5:0] idx, input logic [31:0] s,
                                            input bit bad_crc, input bit bad_end);
    logic [39:0] f = {2'b00, idx, s};
    logic [6:0]  c = bcrc(f) ^ {6'b0, bad_crc};
    return {88'b0, f, c, ~bad_end};
  endfunction

  // monitor: ticks for the next edge, then sample the host line
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    sd_tick = (tdiv == 0);
    if (sd_tick && cmd_oe) begin
      mon_sr = {mon_sr[46:0], cmd_out};
      mon_n++;
      if (mon_n == 48) begin
        mon_n = 0;
        n_chk++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R2/R4: frame %h seen, expected none", mon_sr);
        end else begin
          mon_exp = exp_q.pop_front();
          if (mon_sr !== mon_exp) begin
            n_bad++;
            $display("FAIL R2/R3: frame %h expected %h", mon_sr, mon_exp);
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a; #1 d = rd_data;
  endtask

  function automatic logic [47:0] host_frame(input logic [31:0] cw, input logic [31:0] arg);
    return {2'b01, cw[5:0], arg, bcrc({2'b01, cw[5:0], arg}), 1'b1};
  endfunction

  task automatic wait_frame_end();
    while (!cmd_oe) @(negedge clk);
    while (cmd_oe) @(negedge clk);
  endtask

  task automatic issue(input logic [31:0] cw, input logic [31:0] arg);
    exp_q.push_back(host_frame(cw, arg));
    wr(10'h008, arg);
    wr(10'h000, cw);
    wait_frame_end();
  endtask

  task automatic card_bit(input logic b);
    cmd_in = b;
    do @(posedge clk); while (!sd_tick);
    @(negedge clk);
  endtask

  task automatic card_send(input int idle, input logic [135:0] fr, input int len);
    repeat (idle) card_bit(1'b1);
    for (int i = len - 1; i >= 0; i--) card_bit(fr[i]);
    cmd_in = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [119:0] body;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(10'h038, v); chk("R1 done reg", v, 32'h0);
    rd(10'h03c, v); chk("R1 err/busy reg", v, 32'h0);
    rd(10'h018, v); chk("R1 resp reg", v, 32'h0);
    chk("R1 idle line", {30'b0, cmd_oe, cmd_out}, 32'h1);

    // R5/R3 clean R1 with data flags set
    issue(32'h0000_1C11, 32'h1234_5678);
    card_send(5, mk_short(6'd17, 32'h0000_0900, 0, 0), 48);
    rd(10'h018, v); chk("R5 short status", v, 32'h0000_0900);
    rd(10'h038, v); chk("R5 done flag", v, 32'h1);
    rd(10'h03c, v); chk("R8 R9 R10 clean response", v, 32'h0);
    rd(10'h000, v); chk("R3 command readback", v, 32'h0000_1C11);
    wr(10'h038, 32'h0);
    rd(10'h038, v); chk("R12 done cleared", v, 32'h0);

    // R6 long response, bad crc and foreign index ignored
    body = 120'hA1B2C3_D4E5F607_18293A4B_5C6D7E8F;
    issue(32'h0000_0602, 32'h0);
    card_send(0, {2'b00, 6'h3f, body, 7'h55, 1'b1}, 136);
    rd(10'h030, v); chk("R6 top word", v, {8'h0, body[119:96]});
    rd(10'h028, v); chk("R6 word 54", v, body[95:64]);
    rd(10'h020, v); chk("R6 word 32", v, body[63:32]);
    rd(10'h018, v); chk("R6 word 10", v, body[31:0]);
    rd(10'h03c, v); chk("R8 R10 skipped for long", v, 32'h0);

    // R8 type 7 skips crc/index
    issue(32'h0000_0729, 32'h40FF_8000);
    card_send(2, mk_short(6'h3f, 32'h80FF_8000, 1, 0), 48);
    rd(10'h018, v); chk("R5 R3-type status", v, 32'h80FF_8000);
    rd(10'h03c, v); chk("R8 crc skipped for type 7", v, 32'h0);

    // R8 crc error
    issue(32'h0000_040D, 32'hCAFE_0001);
    card_send(3, mk_short(6'd13, 32'h0000_0A00, 1, 0), 48);
    rd(10'h03c, v); chk("R8 crc error", v, 32'h2);
    wr(10'h03c, 32'h0);
    rd(10'h03c, v); chk("R12 errors cleared", v, 32'h0);

    // R9 end-bit error
    issue(32'h0000_040D, 32'hCAFE_0002);
    card_send(1, mk_short(6'd13, 32'h0000_0B00, 0, 1), 48);
    rd(10'h03c, v); chk("R9 end bit error", v, 32'h4);
    wr(10'h03c, 32'h0);

    // R10 index mismatch plus bad end; selective clear R12
    issue(32'h0000_040D, 32'hCAFE_0003);
    card_send(1, mk_short(6'd14, 32'h0000_0C00, 0, 1), 48);
    rd(10'h03c, v); chk("R10 index mismatch", v, 32'h5);
    wr(10'h03c, 32'hFFFF_FFFE);
    rd(10'h03c, v); chk("R12 selective clear", v, 32'h4);
    wr(10'h03c, 32'h0);
    wr(10'h038, 32'h0);
    rd(10'h018, last_r10);

    // R7 timeout boundary
    issue(32'h0000_0437, 32'h0);
    repeat (63) card_bit(1'b1);
    rd(10'h03c, v); chk("R7 still waiting after 63", v, 32'h4000);
    card_bit(1'b1);
    rd(10'h03c, v); chk("R7 timeout flag", v, 32'h40);
    rd(10'h038, v); chk("R7 no done", v, 32'h0);
    rd(10'h018, v); chk("R7 resp unchanged", v, last_r10);
    wr(10'h03c, 32'h0);

    // R7 start bit on 64th sample accepted
    issue(32'h0000_0437, 32'h1);
    card_send(63, mk_short(6'd55, 32'h0000_0920, 0, 0), 48);
    rd(10'h018, v); chk("R7 late start accepted", v, 32'h0000_0920);
    rd(10'h03c, v); chk("R7 no timeout on 64th", v, 32'h0);
    wr(10'h038, 32'h0);

    // R11 no-response command
    issue(32'h0000_0300, 32'h0);
    rd(10'h038, v); chk("R11 done after end bit", v, 32'h1);
    rd(10'h03c, v); chk("R11 not busy", v, 32'h0);
    card_send(0, mk_short(6'd0, 32'hDEAD_BEEF, 0, 0), 48);
    rd(10'h018, v); chk("R11 line ignored", v, 32'h0000_0920);
    rd(10'h03c, v); chk("R11 no flags from line", v, 32'h0);
    wr(10'h038, 32'h0);

    // R4 write while busy ignored
    exp_q.push_back(host_frame(32'h0000_0407, 32'h0000_7777));
    wr(10'h008, 32'h0000_7777);
    wr(10'h000, 32'h0000_0407);
    wr(10'h000, 32'h0000_0308);
    rd(10'h03c, v); chk("R4 busy while sending", v, 32'h4000);
    rd(10'h000, v); chk("R4 command kept", v, 32'h0000_0407);
    wait_frame_end();
    rd(10'h03c, v); chk("R4 busy while waiting", v, 32'h4000);
    card_send(2, mk_short(6'd7, 32'h0000_0123, 0, 0), 48);
    rd(10'h018, v); chk("R4 first command completes", v, 32'h0000_0123);
    rd(10'h03c, v); chk("R4 idle after response", v, 32'h0);
    repeat (300) @(negedge clk);
    chk("R4 no extra frame", exp_q.size(), 32'h0);
    chk("R2 no partial frame", mon_n, 32'h0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule